// File: doc/BRIEF.md
# Configurable-Rate System Counter with Compare

This block derives a system tick count from a free-running 64-bit nanosecond time base. The tick frequency is fixed at build time by a parameter in Hz. From it the block derives a whole-nanosecond tick period: one billion divided by the frequency, with the remainder dropped. The period is clamped to 1 ns for frequencies of 1 GHz and above. A sequential divider samples the time base, converts it to ticks, and announces each new count with a one-cycle strobe. It then starts over at once.

The count is compared against a software-supplied compare value. The result drives a match flag and a maskable interrupt. The block also reports how many nanoseconds remain until the compare point. That figure saturates at the largest positive signed 64-bit value instead of wrapping. A readable frequency register starts out holding the configured frequency. Software may overwrite it, but that only changes what reads back. A configured frequency of zero is rejected: an error flag rises and the counter stays at zero.

Top module: `sysctr_top`

## Requirements
- R1: The tick period is floor(1e9 / FREQ_HZ) ns for 0 < FREQ_HZ < 1e9, and exactly 1 ns for FREQ_HZ >= 1e9.
- R2: The divider samples `time_ns` on the first clock edge after reset and again on the edge after each strobe. Exactly 64 edges after a sample, `count` becomes floor(sample / period) and `count_vld` is high for that one cycle. `count` changes only when `count_vld` is high.
- R3: With FREQ_HZ = 0, `cfg_err` reads 1, `count` stays 0 and `count_vld` never rises. For any other frequency, `cfg_err` reads 0.
- R4: With the default FREQ_HZ of 62,500,000, the period is 16 ns.
- R5: After reset, `freq_rd` equals FREQ_HZ. A cycle with `freq_wr` high stores `freq_wdata`, which reads back from the next cycle on. Such writes leave the tick period unchanged.
- R6: One cycle after a clock edge, `match` equals `enable` AND (`count` >= `cmp_val`), both taken as they were before that edge.
- R7: `irq` follows the same timing as `match`, further gated by `irq_mask`.
- R8: Any edge taken with `enable` low leaves both `match` and `irq` at 0 in the following cycle.
- R9: One cycle after an edge, `deadline_ns` shows the time left to the compare point, using the pre-edge `count` and `cmp_val`. If `cmp_val` is not above `count`, it is 0. Otherwise let delta = `cmp_val` − `count`. The output is delta × period, or 2^63−1 when delta exceeds floor((2^63−1) / period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_ns | input | TW | Free-running nanosecond time base |
| cmp_val | input | TW | Compare value in ticks |
| enable | input | 1 | Enables match and interrupt |
| irq_mask | input | 1 | Interrupt gate (1 = pass) |
| freq_wr | input | 1 | Write strobe for the frequency register |
| freq_wdata | input | FW | Data for the frequency register |
| count | output | TW | Tick count |
| count_vld | output | 1 | One-cycle strobe for a new count |
| freq_rd | output | FW | Frequency register read value |
| match | output | 1 | Count has reached the compare value while enabled |
| irq | output | 1 | Masked match |
| deadline_ns | output | TW | Saturating nanoseconds left to the compare point |
| cfg_err | output | 1 | Invalid (zero) frequency configured |

## Verification
A corrupted divider remainder or quotient bit shows up as a wrong `count` at the very next strobe, at most 65 cycles later. A mis-sequenced iteration counter shifts the strobe away from its 65-cycle cadence and is caught in the first cycle that differs. Errors in the compare stage surface one cycle after the faulty input pair, on `match`, `irq` or `deadline_ns`. Four build variants run side by side: exact, truncating, clamped and zero frequency. Together they expose a wrong period derivation at the first strobe.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;

  // Whole-nanosecond tick period; zero frequency yields a dummy 1.
  function automatic logic [63:0] period_of(input logic [63:0] freq_hz);
    if (freq_hz == 64'd0)
      return 64'd1;
    else if (freq_hz >= NS_PER_SEC)
      return 64'd1;
    else
      return NS_PER_SEC / freq_hz;
  endfunction
endpackage

// File: rtl/sysctr_div.sv
module sysctr_div #(
  parameter int          TW      = 64,
  parameter logic [63:0] DIVISOR = 64'd16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [TW-1:0] num_i,
  output logic [TW-1:0] quo_o,
  output logic          vld_o
);
  localparam int ITW = $clog2(TW + 1);
  localparam logic [TW:0] DIV_X = {1'b0, DIVISOR[TW-1:0]};
  localparam logic [ITW-1:0] LAST = ITW'(TW - 1);

  logic          busy;
  logic [ITW-1:0] iter;
  logic [TW-1:0] rem;
  logic [TW-1:0] quo;
  logic [TW:0]   trial;
  logic          take;
  logic [TW-1:0] rem_nx;
  logic [TW-1:0] quo_nx;

  always_comb begin
    trial  = {rem, quo[TW-1]};
    take   = (trial >= DIV_X);
    rem_nx = take ? TW'(trial - DIV_X) : trial[TW-1:0];
    quo_nx = {quo[TW-2:0], take};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      iter  <= '0;
      rem   <= '0;
      quo   <= '0;
      quo_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!hold) begin
        if (!busy) begin
          quo  <= num_i;
          rem  <= '0;
          iter <= '0;
          busy <= 1'b1;
        end else begin
          rem  <= rem_nx;
          quo  <= quo_nx;
          iter <= iter + 1'b1;
          if (iter == LAST) begin
            busy  <= 1'b0;
            quo_o <= quo_nx;
            vld_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sysctr_cmp.sv
module sysctr_cmp #(
  parameter int          TW     = 64,
  parameter logic [63:0] PERIOD = 64'd16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] count_i,
  input  logic [TW-1:0] cmp_i,
  input  logic          en_i,
  input  logic          mask_i,
  output logic          match_o,
  output logic          irq_o,
  output logic [TW-1:0] dl_o
);
  localparam logic [TW-1:0] SAT   = {1'b0, {(TW-1){1'b1}}};
  localparam logic [TW-1:0] PER_W = PERIOD[TW-1:0];
  localparam logic [TW-1:0] LIM   = SAT / PER_W;

  logic          reached;
  logic [TW-1:0] delta;
  logic [TW-1:0] dl_nx;

  always_comb begin
    reached = (count_i >= cmp_i);
    delta   = cmp_i - count_i;
    if (reached)
      dl_nx = '0;
    else if (delta > LIM)
      dl_nx = SAT;
    else
      dl_nx = delta * PER_W;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o <= 1'b0;
      irq_o   <= 1'b0;
      dl_o    <= '0;
    end else begin
      match_o <= en_i & reached;
      irq_o   <= en_i & reached & mask_i;
      dl_o    <= dl_nx;
    end
  end
endmodule

// File: rtl/sysctr_freg.sv
module sysctr_freg #(
  parameter int          FW   = 64,
  parameter logic [63:0] INIT = 64'd62_500_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [FW-1:0] wdata_i,
  output logic [FW-1:0] rd_o
);
  always_ff @(posedge clk) begin
    if (rst)
      rd_o <= INIT[FW-1:0];
    else if (wr_i)
      rd_o <= wdata_i;
  end
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
  import sysctr_pkg::*;
#(
  parameter int          TW      = 64,
  parameter int          FW      = 64,
  parameter logic [63:0] FREQ_HZ = 64'd62_500_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_ns,
  input  logic [TW-1:0] cmp_val,
  input  logic          enable,
  input  logic          irq_mask,
  input  logic          freq_wr,
  input  logic [FW-1:0] freq_wdata,
  output logic [TW-1:0] count,
  output logic          count_vld,
  output logic [FW-1:0] freq_rd,
  output logic          match,
  output logic          irq,
  output logic [TW-1:0] deadline_ns,
  output logic          cfg_err
);
  localparam logic [63:0] PERIOD = period_of(FREQ_HZ);
  localparam logic        BAD    = (FREQ_HZ == 64'd0);

  always_ff @(posedge clk) begin
    cfg_err <= BAD;
  end

  sysctr_div #(.TW(TW), .DIVISOR(PERIOD)) u_div (
    .clk   (clk),
    .rst   (rst),
    .hold  (BAD),
    .num_i (time_ns),
    .quo_o (count),
    .vld_o (count_vld)
  );

  sysctr_cmp #(.TW(TW), .PERIOD(PERIOD)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .count_i (count),
    .cmp_i   (cmp_val),
    .en_i    (enable),
    .mask_i  (irq_mask),
    .match_o (match),
    .irq_o   (irq),
    .dl_o    (deadline_ns)
  );

  sysctr_freg #(.FW(FW), .INIT(FREQ_HZ)) u_freg (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (freq_wr),
    .wdata_i (freq_wdata),
    .rd_o    (freq_rd)
  );
endmodule

// File: rtl/sysctr_chk.sv
module sysctr_chk #(
  parameter int TW = 64,
  parameter int FW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          freq_wr,
  input logic [FW-1:0] freq_wdata,
  input logic [TW-1:0] count,
  input logic          count_vld,
  input logic [FW-1:0] freq_rd,
  input logic          match,
  input logic          irq,
  input logic [TW-1:0] deadline_ns,
  input logic          cfg_err
);
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    count_vld |=> !count_vld);

  p_count_moves_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> count_vld);

  p_err_holds_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (count == '0 && !count_vld));

  p_freq_write_r5: assert property (@(posedge clk) disable iff (rst)
    freq_wr |=> (freq_rd == $past(freq_wdata)));

  p_irq_implies_match_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> match);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!match && !irq));

  p_deadline_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    !deadline_ns[TW-1]);
endmodule

bind sysctr_top sysctr_chk #(.TW(TW), .FW(FW)) i_sysctr_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .freq_wr     (freq_wr),
  .freq_wdata  (freq_wdata),
  .count       (count),
  .count_vld   (count_vld),
  .freq_rd     (freq_rd),
  .match       (match),
  .irq         (irq),
  .deadline_ns (deadline_ns),
  .cfg_err     (cfg_err)
);

// File: tb/test_sysctr_top.sv
`timescale 1ns/1ps
module test_sysctr_top;
  localparam int NI = 4;
  localparam logic [63:0] FR [NI] = '{64'd62_500_000, 64'd300_000_000,
                                      64'd1_500_000_000, 64'd0};
  localparam logic [63:0] SATV = 64'h7FFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_ns = '0;
  logic [63:0] cmp_val = '0;
  logic        enable = 1'b0;
  logic        irq_mask = 1'b0;
  logic        freq_wr = 1'b0;
  logic [63:0] freq_wdata = '0;

  logic [63:0] o_cnt [NI];
  logic        o_vld [NI];
  logic [63:0] o_frq [NI];
  logic        o_mat [NI];
  logic        o_irq [NI];
  logic [63:0] o_dl  [NI];
  logic        o_err [NI];

  always #2.5 clk = ~clk;

  sysctr_top #(.FREQ_HZ(FR[0])) i_sysctr_top (
    .clk(clk), .rst(rst), .time_ns(time_ns), .cmp_val(cmp_val),
    .enable(enable), .irq_mask(irq_mask), .freq_wr(freq_wr),
    .freq_wdata(freq_wdata), .count(o_cnt[0]), .count_vld(o_vld[0]),
    .freq_rd(o_frq[0]), .match(o_mat[0]), .irq(o_irq[0]),
    .deadline_ns(o_dl[0]), .cfg_err(o_err[0]));

  for (genvar g = 1; g < NI; g++) begin : g_var
    sysctr_top #(.FREQ_HZ(FR[g])) i_sysctr_top (
      .clk(clk), .rst(rst), .time_ns(time_ns), .cmp_val(cmp_val),
      .enable(enable), .irq_mask(irq_mask), .freq_wr(freq_wr),
      .freq_wdata(freq_wdata), .count(o_cnt[g]), .count_vld(o_vld[g]),
      .freq_rd(o_frq[g]), .match(o_mat[g]), .irq(o_irq[g]),
      .deadline_ns(o_dl[g]), .cfg_err(o_err[g]));
  end

  // reference model state
  logic [63:0] per  [NI];
  logic        m_busy [NI];
  int          m_it [NI];
  logic [63:0] m_t  [NI];
  logic [63:0] e_cnt [NI];
  logic        e_vld [NI];
  logic [63:0] e_frq [NI];
  logic        e_mat [NI];
  logic        e_irq [NI];
  logic [63:0] e_dl  [NI];

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  task automatic chk(input string tag, input int idx, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst=%0d act=%h exp=%h", tag, idx, act, exp);
    end
  endtask

  function automatic logic [63:0] period_req(input logic [63:0] f);
    if (f == 0) return 64'd1;            // unused for counting (R3)
    if (f >= 64'd1_000_000_000) return 64'd1;
    return 64'd1_000_000_000 / f;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NI; i++) begin
      per[i] = period_req(FR[i]);
      m_busy[i] = 1'b0; m_it[i] = 0; m_t[i] = '0;
      e_cnt[i] = '0; e_vld[i] = 1'b0; e_frq[i] = FR[i];
      e_mat[i] = 1'b0; e_irq[i] = 1'b0; e_dl[i] = '0;
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < NI; i++) begin
      logic [63:0] c_old;
      c_old = e_cnt[i];
      e_mat[i] = enable && (c_old >= cmp_val);
      e_irq[i] = enable && irq_mask && (c_old >= cmp_val);
      if (cmp_val > c_old) begin
        if ((cmp_val - c_old) > SATV / per[i]) e_dl[i] = SATV;
        else e_dl[i] = (cmp_val - c_old) * per[i];
      end else e_dl[i] = '0;
      if (freq_wr) e_frq[i] = freq_wdata;
      e_vld[i] = 1'b0;
      if (FR[i] != 0) begin
        if (!m_busy[i]) begin
          m_busy[i] = 1'b1; m_it[i] = 0; m_t[i] = time_ns;
        end else begin
          m_it[i]++;
          if (m_it[i] == 64) begin
            m_busy[i] = 1'b0;
            e_vld[i] = 1'b1;
            e_cnt[i] = m_t[i] / per[i];
          end
        end
      end
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NI; i++) begin
      chk("R2 count (R1 period, R5 rate kept)", i, o_cnt[i], e_cnt[i]);
      chk("R2 strobe", i, 64'(o_vld[i]), 64'(e_vld[i]));
      chk("R5 freq reg", i, o_frq[i], e_frq[i]);
      chk("R6 match / R8", i, 64'(o_mat[i]), 64'(e_mat[i]));
      chk("R7 irq / R8", i, 64'(o_irq[i]), 64'(e_irq[i]));
      chk("R9 deadline", i, o_dl[i], e_dl[i]);
      chk("R3 cfg_err", i, 64'(o_err[i]), 64'(FR[i] == 0));
      if (i == 0 && e_vld[0])
        chk("R4 period 16", 0, o_cnt[0], m_t[0] / 64'd16);
    end
  endtask

  task automatic step(input logic [63:0] t, input logic [63:0] c,
                      input logic en, input logic mk,
                      input logic wr, input logic [63:0] wd);
    @(negedge clk);
    compare_all();
    time_ns = t; cmp_val = c; enable = en; irq_mask = mk;
    freq_wr = wr; freq_wdata = wd;
    if (rst) model_reset(); else model_step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] t;
    model_reset();
    repeat (4) step(64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 64'd0);
    @(negedge clk);
    compare_all();
    rst = 1'b0;
    model_step();
    t = 64'd0;
    // A: slow time, compare at 1000 ticks
    for (int k = 0; k < 300; k++) begin
      t = t + 64'd7;
      step(t, 64'd1000, 1'b1, 1'b1, 1'b0, 64'd0);
    end
    // B: register writes, then disable
    for (int k = 0; k < 200; k++) begin
      t = t + 64'd11;
      step(t, 64'd200, (k < 100), 1'b1, (k == 20 || k == 150),
           64'd123 + 64'(k));
    end
    // C: far compare, masked, time near 2^63
    for (int k = 0; k < 300; k++) begin
      step(64'h8000_0000_0000_0000 + 64'(13 * k), 64'hFFFF_FFFF_FFFF_FFFF,
           1'b1, 1'b0, 1'b0, 64'd0);
    end
    // D: top of time range, mid compare, unmasked
    for (int k = 0; k < 300; k++) begin
      step(64'hFFFF_FFFF_FFFF_F000 + 64'(k), 64'h0000_1000_0000_0000,
           (k % 50) < 40, 1'b1, 1'b0, 64'd0);
    end
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule